// File: doc/BRIEF.md
# Vectored Interrupt Controller with Masking

This block collects 128 level-sensitive interrupt sources, grouped in four banks of 32, and presents one interrupt line to a processor. Each source can be masked, and software can raise any source by setting a software-trigger bit that acts exactly like the hardware pin. Among the unmasked sources that are pending, the controller picks the lowest source number. It freezes that number and raises `irq_out`.

The handler reads the active-number register to learn which source to serve. It then writes the release bit in the control register, and the controller picks the next winner. A read also shows whether the frozen source is still asserted. If the source has gone away, or was masked after it was selected, bit 7 of the value is set and the handler treats the result as spurious.

A soft reset returns all programmable state to its reset values. A status bit tells software when that sequence has finished. The block is accessed through a simple 32-bit register port: writes take effect on the clock edge, and reads are combinational from the address.

Top module: `intc_vectored`

## Requirements
- R1: After reset, every source is masked, every software trigger is clear, `irq_out` is low, the threshold reads 0xFF, status (0x14) bit 0 reads 1, and the active register (0x40) reads 0x80.
- R2: Address 0x00 reads the revision: major number in bits 7:4 and minor number in bits 3:0. The default is 5.0, which reads 0x50.
- R3: Bank b has a mask-clear register at 0x88+32b and a mask-set register at 0x8C+32b. Writing a one to a bit clears or sets that mask bit, and a zero bit leaves it unchanged. Both addresses read back the bank's current mask, and a masked source is never selected.
- R4: Bank b has a software-set register at 0x90+32b and a software-clear register at 0x94+32b. They set and clear trigger bits with the same write-one behaviour, and both addresses read back the current trigger bits. A set trigger is pending just like a hardware input.
- R5: Source n lives in bank n>>5 at bit n&31. A hardware input is registered once, so a pending source is (input | trigger) & ~mask.
- R6: When nothing is frozen, at least one source is pending and the threshold allows it, the lowest pending source number is frozen on the next edge. `irq_out` rises two edges after a hardware pin is asserted, and one edge after a trigger-set write.
- R7: While a number is frozen, it and `irq_out` stay unchanged until a write to 0x48 with bit 0 set. A write there with bit 0 clear has no effect. After the release write, `irq_out` is low for one cycle and sorting then resumes.
- R8: Address 0x40 reads the frozen number in bits 6:0. Bit 7 is set if the frozen source is no longer pending. With nothing frozen, the register reads 0x80. Bits 31:8 always read 0.
- R9: Address 0x68 holds an 8-bit threshold. Every source has fixed priority 0. A value of 0xFF disables filtering, and any other value lets a source through only if 0 is below the threshold, so a threshold of 0 stops new selections.
- R10: Writing a value with bit 1 set to 0x10 starts a soft reset. Status bit 0 then reads 0 for 4 cycles and 1 afterwards. Masks, triggers, threshold and the frozen number return to their reset values, writes made during the sequence are ignored, and 0x10 reads 0.
- R11: Unmapped, misaligned or read-only addresses read 0, or their fixed value, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 128 | Level-sensitive source inputs, source n at bit n |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Wrong state shows up at the ports within a cycle or two. A stale mask or trigger bit appears in the bank read-back immediately. It also changes which number gets frozen two edges after the stimulus. A freeze flag that fails to release leaves `irq_out` high after a release write, while a premature re-sort changes the 0x40 value while `irq_out` stays high. Both are visible in the cycle after the edge. A soft-reset counter that is off by one changes the status bit exactly at the fourth cycle. The bench compares the outputs and read data against its own model on every clock, so such a fault is caught within the cycle in which it first becomes observable.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int DATA_W      = 32;
   localparam int BANK_STRIDE = 32;
   localparam int SPUR_BIT    = 7;

   localparam logic [7:0] OFS_REV       = 8'h00;
   localparam logic [7:0] OFS_SYSCFG    = 8'h10;
   localparam logic [7:0] OFS_SYSSTAT   = 8'h14;
   localparam logic [7:0] OFS_ACTIVE    = 8'h40;
   localparam logic [7:0] OFS_CTRL      = 8'h48;
   localparam logic [7:0] OFS_THRESH    = 8'h68;
   localparam logic [7:0] OFS_BANK_BASE = 8'h88;
   localparam logic [7:0] THR_OPEN      = 8'hFF;

   // per-bank register function, selected by address bits 3:2 of the bank offset
   typedef enum logic [1:0] {
      FN_MASK_CLR = 2'd0,
      FN_MASK_SET = 2'd1,
      FN_SWI_SET  = 2'd2,
      FN_SWI_CLR  = 2'd3
   } bank_fn_e;
endpackage

// File: rtl/intc_bank.sv
module intc_bank
   import intc_pkg::*;
#(
   parameter int BANK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclr,
   input  logic              wr_en,
   input  bank_fn_e          fn,
   input  logic [BANK_W-1:0] wdata,
   output logic [BANK_W-1:0] mask_q,
   output logic [BANK_W-1:0] swi_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
         swi_q  <= '0;
      end else if (sclr) begin
         mask_q <= '1;
         swi_q  <= '0;
      end else if (wr_en) begin
         case (fn)
            FN_MASK_CLR: mask_q <= mask_q & ~wdata;
            FN_MASK_SET: mask_q <= mask_q | wdata;
            FN_SWI_SET:  swi_q  <= swi_q | wdata;
            FN_SWI_CLR:  swi_q  <= swi_q & ~wdata;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/intc_prio_sort.sv
module intc_prio_sort #(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 32,
   parameter bit TWO_LEVEL = 1'b1,
   localparam int NSRC     = NUM_BANKS * BANK_W,
   localparam int ID_W     = $clog2(NSRC)
) (
   input  logic [NSRC-1:0] pend,
   output logic            any,
   output logic [ID_W-1:0] win_id
);

   localparam int LOC_W = (BANK_W > 1) ? $clog2(BANK_W) : 1;

   if (TWO_LEVEL) begin : g_two
      logic [NUM_BANKS-1:0]            b_any;
      logic [NUM_BANKS-1:0][LOC_W-1:0] b_loc;

      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bk
         logic             any_b;
         logic [LOC_W-1:0] loc_b;
         always_comb begin
            any_b = |pend[b*BANK_W +: BANK_W];
            loc_b = '0;
            for (int i = BANK_W - 1; i >= 0; i--) begin
               if (pend[b*BANK_W + i]) loc_b = LOC_W'(i);
            end
         end
         assign b_any[b] = any_b;
         assign b_loc[b] = loc_b;
      end

      always_comb begin
         any    = |b_any;
         win_id = '0;
         for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (b_any[b]) win_id = ID_W'(b * BANK_W + int'(b_loc[b]));
         end
      end
   end else begin : g_flat
      always_comb begin
         any    = |pend;
         win_id = '0;
         for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) win_id = ID_W'(i);
         end
      end
   end

endmodule

// File: rtl/intc_softrst_seq.sv
module intc_softrst_seq #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int CNT_W = $clog2(CYCLES + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= CNT_W'(CYCLES - 1);
      end else if (busy) begin
         if (cnt_q == '0) busy <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/intc_vectored.sv
module intc_vectored
   import intc_pkg::*;
#(
   parameter int         NUM_BANKS   = 4,
   parameter int         BANK_W      = 32,
   parameter int         ADDR_W      = 8,
   parameter int         REV_MAJOR   = 5,
   parameter int         REV_MINOR   = 0,
   parameter int         SRST_CYCLES = 4,
   parameter bit         TWO_LEVEL   = 1'b1,
   parameter logic [7:0] FIXED_PRIO  = 8'd0,
   localparam int        NSRC        = NUM_BANKS * BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   irq_src,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_out
);

   localparam int ID_W     = $clog2(NSRC);
   localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int BANK_END = int'(OFS_BANK_BASE) + (NUM_BANKS - 1) * BANK_STRIDE + 16;

   localparam logic [ADDR_W-1:0] A_REV   = ADDR_W'(OFS_REV);
   localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFS_SYSCFG);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_SYSSTAT);
   localparam logic [ADDR_W-1:0] A_ACT   = ADDR_W'(OFS_ACTIVE);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_THR   = ADDR_W'(OFS_THRESH);
   localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(OFS_BANK_BASE);
   localparam logic [ADDR_W-1:0] REL_END = ADDR_W'(BANK_END - int'(OFS_BANK_BASE));

   // elaboration-time parameter checks
   if (BANK_W != DATA_W) begin : g_bad_bank_w
      $error("BANK_W must equal the register width");
   end
   if (ID_W > SPUR_BIT) begin : g_bad_nsrc
      $error("source number must fit below the spurious flag bit");
   end
   if (ADDR_W < 8 || BANK_END >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the bank registers");
   end
   if (SRST_CYCLES < 1) begin : g_bad_srst
      $error("SRST_CYCLES must be at least 1");
   end
   if (REV_MAJOR > 15 || REV_MINOR > 15 || REV_MAJOR < 0 || REV_MINOR < 0) begin : g_bad_rev
      $error("revision fields are 4 bits each");
   end

   // write qualification
   logic srst_busy, srst_start, sclr, wr_ok, agree, thr_wr;

   assign wr_ok      = reg_wr && !srst_busy;
   assign srst_start = wr_ok && (reg_addr == A_CFG) && reg_wdata[1];
   assign sclr       = srst_start || srst_busy;
   assign agree      = wr_ok && (reg_addr == A_CTRL) && reg_wdata[0];
   assign thr_wr     = wr_ok && (reg_addr == A_THR);

   intc_softrst_seq #(.CYCLES(SRST_CYCLES)) u_srst (
      .clk   (clk),
      .rst_n (rst_n),
      .start (srst_start),
      .busy  (srst_busy)
   );

   // bank address decode
   logic [ADDR_W-1:0] rel;
   logic              in_bank;
   logic [BSEL_W-1:0] bsel;
   bank_fn_e          bfn;

   assign rel     = reg_addr - A_BASE;
   assign in_bank = (reg_addr >= A_BASE) && (rel < REL_END) && !rel[4] && (rel[1:0] == 2'b00);
   assign bsel    = rel[5 +: BSEL_W];
   assign bfn     = bank_fn_e'(rel[3:2]);

   logic [NUM_BANKS-1:0][BANK_W-1:0] mask_pk, swi_pk;
   logic [NSRC-1:0]                  mask_flat, swi_flat;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic we_b;
      assign we_b = wr_ok && in_bank && (bsel == BSEL_W'(b));
      intc_bank #(.BANK_W(BANK_W)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .sclr   (sclr),
         .wr_en  (we_b),
         .fn     (bfn),
         .wdata  (reg_wdata),
         .mask_q (mask_pk[b]),
         .swi_q  (swi_pk[b])
      );
   end

   assign mask_flat = mask_pk;
   assign swi_flat  = swi_pk;

   // input capture and pending vector
   logic [NSRC-1:0] hw_q, pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hw_q <= '0;
      else        hw_q <= irq_src;
   end

   assign pend = (hw_q | swi_flat) & ~mask_flat;

   // threshold register
   logic [7:0] thr_q;
   logic       thr_pass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      thr_q <= THR_OPEN;
      else if (sclr)   thr_q <= THR_OPEN;
      else if (thr_wr) thr_q <= reg_wdata[7:0];
   end

   assign thr_pass = (thr_q == THR_OPEN) || (FIXED_PRIO < thr_q);

   // sorter and freeze handshake
   logic            sort_any;
   logic [ID_W-1:0] sort_id, act_id_q;
   logic            held_q, act_live;

   intc_prio_sort #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .TWO_LEVEL (TWO_LEVEL)
   ) u_sort (
      .pend   (pend),
      .any    (sort_any),
      .win_id (sort_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q   <= 1'b0;
         act_id_q <= '0;
      end else if (sclr) begin
         held_q   <= 1'b0;
         act_id_q <= '0;
      end else if (held_q) begin
         if (agree) held_q <= 1'b0;
      end else if (thr_pass && sort_any) begin
         held_q   <= 1'b1;
         act_id_q <= sort_id;
      end
   end

   assign irq_out  = held_q;
   assign act_live = pend[act_id_q];

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_REV:  reg_rdata[7:0] = {4'(REV_MAJOR), 4'(REV_MINOR)};
         A_STAT: reg_rdata[0]   = !srst_busy;
         A_THR:  reg_rdata[7:0] = thr_q;
         A_ACT: begin
            if (held_q) begin
               reg_rdata[ID_W-1:0] = act_id_q;
               reg_rdata[SPUR_BIT] = !act_live;
            end else begin
               reg_rdata[SPUR_BIT] = 1'b1;
            end
         end
         default: begin
            if (in_bank) begin
               if (bfn == FN_MASK_CLR || bfn == FN_MASK_SET) reg_rdata = mask_pk[bsel];
               else                                          reg_rdata = swi_pk[bsel];
            end
         end
      endcase
   end

endmodule

// File: rtl/intc_vectored_chk.sv
module intc_vectored_chk
   import intc_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 32,
   parameter int ADDR_W    = 8,
   localparam int NSRC     = NUM_BANKS * BANK_W,
   localparam int ID_W     = $clog2(NSRC)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              irq_out,
   input logic              busy,
   input logic [ID_W-1:0]   act_id,
   input logic [NSRC-1:0]   pend,
   input logic [NSRC-1:0]   mask_flat
);

   localparam logic [ADDR_W-1:0] C_CFG  = ADDR_W'(OFS_SYSCFG);
   localparam logic [ADDR_W-1:0] C_ACT  = ADDR_W'(OFS_ACTIVE);
   localparam logic [ADDR_W-1:0] C_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] C_MSET = ADDR_W'(OFS_BANK_BASE) + ADDR_W'(4);

   logic agree_now, start_now;
   logic [NSRC-1:0] pend_d, below;

   assign agree_now = reg_wr && !busy && (reg_addr == C_CTRL) && reg_wdata[0];
   assign start_now = reg_wr && !busy && (reg_addr == C_CFG) && reg_wdata[1];
   assign below     = (NSRC'(1) << act_id) - NSRC'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_d <= '0;
      else        pend_d <= pend;
   end

   // R7
   agree_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (agree_now && irq_out) |=> !irq_out);

   // R7
   frozen_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && !agree_now && !start_now) |=> (irq_out && $stable(act_id)));

   // R6
   lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> (pend_d[act_id] && ((pend_d & below) == '0)));

   // R10
   srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_now |=> (busy && !irq_out && (mask_flat == '1)));

   // R3
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !busy && reg_addr == C_MSET) |=>
         ((mask_flat[BANK_W-1:0] & $past(reg_wdata)) == $past(reg_wdata)));

   // R8
   spur_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_out && reg_addr == C_ACT) |-> (reg_rdata == 32'h80));

endmodule

bind intc_vectored intc_vectored_chk #(
   .NUM_BANKS (NUM_BANKS),
   .BANK_W    (BANK_W),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq_out   (irq_out),
   .busy      (srst_busy),
   .act_id    (act_id_q),
   .pend      (pend),
   .mask_flat (mask_flat)
);

// File: tb/tb_intc_vectored.sv
module tb_intc_vectored;

   localparam int SRST = 4;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [127:0] irq_src;
   logic         reg_wr;
   logic [7:0]   reg_addr;
   logic [31:0]  reg_wdata;
   logic [31:0]  reg_rdata;
   logic         irq_out;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   intc_vectored dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_src   (irq_src),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_out   (irq_out)
   );

   // behavioural reference model
   bit [127:0] m_mask, m_swi, m_hw;
   bit         m_held, m_busy;
   int         m_id, m_cnt;
   bit [7:0]   m_thr;

   function automatic bit [127:0] m_pend();
      return (m_hw | m_swi) & ~m_mask;
   endfunction

   function automatic int lowest(bit [127:0] p);
      for (int i = 0; i < 128; i++) if (p[i]) return i;
      return -1;
   endfunction

   function automatic bit bank_hit(bit [7:0] a);
      int ra = int'(a) - 136;
      return (a >= 8'h88) && (a < 8'hF8) && ((ra % 32) < 16) && ((ra % 4) == 0);
   endfunction

   function automatic bit [31:0] m_read(bit [7:0] a);
      bit [127:0] p = m_pend();
      int ra = int'(a) - 136;
      if (a == 8'h00) return 32'h50;
      if (a == 8'h14) return {31'd0, !m_busy};
      if (a == 8'h68) return {24'd0, m_thr};
      if (a == 8'h40) return m_held ? {24'd0, !p[m_id], 7'(m_id)} : 32'h80;
      if (bank_hit(a)) begin
         if (((ra % 32) / 4) < 2) return m_mask[(ra / 32) * 32 +: 32];
         return m_swi[(ra / 32) * 32 +: 32];
      end
      return 32'h0;
   endfunction

   function automatic string atag(bit [7:0] a);
      if (a == 8'h00) return "R2";
      if (a == 8'h10 || a == 8'h14) return "R10";
      if (a == 8'h40) return "R8";
      if (a == 8'h68) return "R9";
      if (bank_hit(a)) return "R3";
      return "R11";
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mask = '1; m_swi = '0; m_hw = '0;
         m_held = 0; m_busy = 0; m_id = 0; m_cnt = 0; m_thr = 8'hFF;
      end else begin
         bit [127:0] p;
         bit wok, start, sclr, agree, pass;
         int ra;
         p     = m_pend();
         wok   = reg_wr && !m_busy;
         start = wok && reg_addr == 8'h10 && reg_wdata[1];
         sclr  = start || m_busy;
         agree = wok && reg_addr == 8'h48 && reg_wdata[0];
         pass  = (m_thr == 8'hFF) || (m_thr > 0);
         if (start) begin m_busy = 1; m_cnt = SRST - 1; end
         else if (m_busy) begin if (m_cnt == 0) m_busy = 0; else m_cnt--; end
         if (sclr) begin
            m_mask = '1; m_swi = '0; m_held = 0; m_id = 0; m_thr = 8'hFF;
         end else begin
            if (m_held) begin
               if (agree) m_held = 0;
            end else if (pass && p != 0) begin
               m_held = 1; m_id = lowest(p);
            end
            if (wok && reg_addr == 8'h68) m_thr = reg_wdata[7:0];
            if (wok && bank_hit(reg_addr)) begin
               ra = int'(reg_addr) - 136;
               case ((ra % 32) / 4)
                  0: m_mask[(ra/32)*32 +: 32] = m_mask[(ra/32)*32 +: 32] & ~reg_wdata;
                  1: m_mask[(ra/32)*32 +: 32] = m_mask[(ra/32)*32 +: 32] | reg_wdata;
                  2: m_swi[(ra/32)*32 +: 32]  = m_swi[(ra/32)*32 +: 32] | reg_wdata;
                  default: m_swi[(ra/32)*32 +: 32] = m_swi[(ra/32)*32 +: 32] & ~reg_wdata;
               endcase
            end
         end
         m_hw = irq_src;
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
      end
   endtask

   // every-clock comparison against the model, plus watchdog
   always @(negedge clk) begin
      cyc++;
      if (rst_n && !done) begin
         chk("R7 irq_out", {31'd0, irq_out}, {31'd0, m_held});
         chk(atag(reg_addr), reg_rdata, m_read(reg_addr));
      end
      if (cyc > 150000 && !done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic wr(bit [7:0] a, bit [31:0] d);
      step();
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      step();
      reg_wr = 0;
   endtask

   task automatic rd(bit [7:0] a, bit [31:0] exp, string tag);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   initial begin
      rst_n = 0; irq_src = '0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
      repeat (3) step();
      rst_n = 1;
      step();

      // R1 / R2 reset state
      rd(8'h00, 32'h50, "R2 revision");
      rd(8'h14, 32'h1, "R1 status");
      rd(8'h68, 32'hFF, "R1 threshold");
      for (int b = 0; b < 4; b++) rd(8'(8'h88 + 32*b), 32'hFFFF_FFFF, "R1 mask");
      rd(8'h90, 32'h0, "R1 swi");
      rd(8'h40, 32'h80, "R1 active");
      chk("R1 irq_out", {31'd0, irq_out}, 32'h0);

      // R3 mask set/clear
      wr(8'h88, 32'h0000_0F00);
      rd(8'h88, 32'hFFFF_F0FF, "R3 mask-clear");
      rd(8'h8C, 32'hFFFF_F0FF, "R3 mask-set readback");
      wr(8'h8C, 32'h0);
      rd(8'h88, 32'hFFFF_F0FF, "R3 zero bits");

      // R5 / R6 hardware pins, lowest wins, two-edge latency
      irq_src[11] = 1; irq_src[9] = 1;
      step();
      chk("R6 not yet", {31'd0, irq_out}, 32'h0);
      step();
      chk("R6 rise", {31'd0, irq_out}, 32'h1);
      rd(8'h40, 32'd9, "R6 lowest");

      // R7 write without bit 0 has no effect
      wr(8'h48, 32'h0);
      rd(8'h40, 32'd9, "R7 hold");
      chk("R7 hold irq", {31'd0, irq_out}, 32'h1);

      // R8 spurious after source drops
      irq_src[9] = 0;
      step();
      rd(8'h40, 32'h89, "R8 spurious");

      // R7 release and re-sort
      wr(8'h48, 32'h1);
      chk("R7 release", {31'd0, irq_out}, 32'h0);
      step();
      chk("R7 re-sort", {31'd0, irq_out}, 32'h1);
      rd(8'h40, 32'd11, "R7 next");

      // R3 masking the held source
      wr(8'h8C, 32'h0000_0800);
      rd(8'h40, 32'h8B, "R8 masked held");
      wr(8'h48, 32'h1);
      step(); step();
      chk("R3 masked no sort", {31'd0, irq_out}, 32'h0);
      irq_src[11] = 0;

      // R4 / R5 software trigger on source 69
      wr(8'hC8, 32'h20);
      wr(8'hD0, 32'h20);
      rd(8'hD0, 32'h20, "R4 swi set");
      step();
      chk("R4 swi irq", {31'd0, irq_out}, 32'h1);
      rd(8'h40, 32'h45, "R5 bank2 bit5");
      wr(8'hD4, 32'h20);
      rd(8'hD4, 32'h0, "R4 swi clear");
      rd(8'h40, 32'hC5, "R8 swi gone");
      wr(8'h48, 32'h1);
      step(); step();
      chk("R4 no irq", {31'd0, irq_out}, 32'h0);

      // R9 threshold
      wr(8'h68, 32'h0);
      rd(8'h68, 32'h0, "R9 readback");
      wr(8'hD0, 32'h20);
      step(); step();
      chk("R9 blocked", {31'd0, irq_out}, 32'h0);
      wr(8'h68, 32'h10);
      step();
      chk("R9 pass", {31'd0, irq_out}, 32'h1);
      rd(8'h40, 32'h45, "R9 active");

      // R10 soft reset
      wr(8'h10, 32'h2);
      rd(8'h14, 32'h0, "R10 busy");
      chk("R10 irq cleared", {31'd0, irq_out}, 32'h0);
      rd(8'hC8, 32'hFFFF_FFFF, "R10 mask reset");
      wr(8'hC8, 32'hFFFF_FFFF);
      rd(8'h14, 32'h0, "R10 busy 3");
      step();
      rd(8'h14, 32'h0, "R10 busy 4");
      step();
      rd(8'h14, 32'h1, "R10 done");
      rd(8'hC8, 32'hFFFF_FFFF, "R10 write ignored");
      rd(8'h68, 32'hFF, "R10 thr reset");
      rd(8'hD0, 32'h0, "R10 swi reset");
      rd(8'h10, 32'h0, "R10 cfg reads 0");

      // R11 unmapped / read-only
      rd(8'h04, 32'h0, "R11 unmapped");
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, 32'h50, "R11 read-only");
      rd(8'hF8, 32'h0, "R11 past banks");
      rd(8'h8A, 32'h0, "R11 misaligned");

      // R5 / R6 bank 3 top bit, then lower source wins after release
      wr(8'hE8, 32'h8000_0000);
      irq_src[127] = 1;
      step(); step();
      rd(8'h40, 32'h7F, "R5 source 127");
      wr(8'hA8, 32'h0000_0100);
      irq_src[40] = 1;
      step();
      wr(8'h48, 32'h1);
      step();
      rd(8'h40, 32'd40, "R6 lower wins");

      // random phase, compared every clock
      wr(8'h88, 32'hFFFF_FFFF);
      wr(8'hA8, 32'hFFFF_FFFF);
      for (int n = 0; n < 4000; n++) begin
         int k;
         step();
         if ($urandom % 3 == 0) irq_src[$urandom % 128] = ~irq_src[$urandom % 128];
         k = $urandom % 8;
         reg_wr = ($urandom % 3 == 0);
         case (k)
            0: begin reg_addr = 8'h48; reg_wdata = $urandom % 2; end
            1, 2: begin
               reg_addr = 8'(8'h88 + 32 * ($urandom % 4) + 4 * ($urandom % 4));
               reg_wdata = $urandom;
            end
            3: begin reg_addr = 8'h68; reg_wdata = ($urandom % 4 == 0) ? 32'h0 : 32'hFF; end
            4: begin reg_addr = 8'h10; reg_wdata = ($urandom % 40 == 0) ? 32'h2 : 32'h1; end
            5: begin reg_addr = 8'h14; reg_wdata = $urandom; end
            default: begin reg_addr = 8'h40; reg_wdata = $urandom; end
         endcase
      end
      step();
      reg_wr = 0;
      step(); step();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule